// File: doc/BRIEF.md
# CAN Transmit Buffer Lock Controller

This block sits between a host register port and a CAN protocol core and decides which of a small bank of message buffers goes on the bus next. Every buffer starts out as a receive buffer. The host reserves a buffer for transmission by setting its reservation bit in a shared lock register. It then requests a frame by writing the last payload byte of that buffer. The block tracks these requests, picks one pending buffer, and runs it through a fixed preparation window of bit times. It then signals start of frame and waits for the core to report the end of the attempt.

The block handles aborts in two ways. A buffer that is only waiting is withdrawn at once when its reservation is dropped. A buffer that is already on the bus keeps its reservation until the attempt ends. During preparation, dropping the reservation of the prepared buffer cancels the frame outright. The selection is held in a register and is never re-derived, so the preparation window can never send a different buffer. Successful attempts leave a sticky per-buffer completion flag, which the host clears by writing 1 to it.

Top module: `can_txlock_ctrl`

## Requirements
- R1: After a synchronous reset, all lock, ready and complete bits are 0, no preparation or transmission is in progress, sof is low and the selected index is 0.
- R2: A host write to control address 0x20 loads the lock vector from host_wdata, with bit i controlling buffer i. A locked buffer no longer accepts reception.
- R3: A host write to buffer address {0, buffer[1:0], byte[2:0]} with byte index 7 sets that buffer's ready bit only if the buffer is locked. A write to byte 7 of an unlocked buffer does nothing, and a write to bytes 0 to 6 does nothing. Ready is never set without lock.
- R4: Clearing the lock of a buffer that is not the one being prepared or transmitted clears its ready bit on the same clock edge. Any preparation or transmission of another buffer continues with the same selection.
- R5: When idle, the controller starts preparing the lowest-index buffer that has both lock and ready set, one cycle later. The selected index does not change from the start of preparation until the attempt ends.
- R6: Preparation lasts two bit_tick pulses. On the edge that takes the second tick, the block enters transmission and pulses sof_o for exactly one cycle.
- R7: Clearing the lock of the buffer under preparation cancels it. This holds even if the clear falls in the same cycle as the final bit tick. No sof is issued, the block returns to idle, and that buffer's lock and ready are cleared.
- R8: While a buffer is being transmitted, clearing its lock has no effect and the attempt continues. A second clear after the attempt ends aborts any retry.
- R9: An end of attempt with success clears the ready bit of the selected buffer and sets its complete bit. An end of attempt without success keeps ready set, so the buffer is prepared again.
- R10: A write to control address 0x21 clears the complete bits that have a 1 in host_wdata. If the same bit is set by a successful attempt in that cycle, the set wins.
- R11: An end-of-attempt report while no transmission is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host address: buffer byte page or control page (bit 5 set) |
| host_wdata | input | 4 | Host write data: lock vector or complete-clear mask |
| bit_tick_i | input | 1 | One pulse per nominal bit time from the core |
| eoa_i | input | 1 | Core reports end of the current transmission attempt |
| eoa_ok_i | input | 1 | Qualifies eoa_i: attempt succeeded |
| lock_o | output | 4 | Per-buffer transmit reservation |
| rdy_o | output | 4 | Per-buffer transmission request pending |
| done_o | output | 4 | Sticky per-buffer transmit-complete flags |
| prep_o | output | 1 | Preparation window in progress |
| active_o | output | 1 | Frame on the bus for the selected buffer |
| sof_o | output | 1 | One-cycle start-of-frame pulse to the core |
| sel_o | output | 2 | Index of the buffer being prepared or sent |

## Verification
Two pairs of events can fall in one cycle here. The first pair is a lock clear for the prepared buffer and the bit tick that would end preparation. The second is a complete-flag clear from the host and the success report that sets the same flag. The bench provokes the first by writing the lock register with bit_tick_i high on the second tick. It expects no sof, idle, and cleared lock and ready. It provokes the second by writing the clear mask while eoa_i and eoa_ok_i are high, and expects the flag to remain set.

// File: rtl/cantxl_pkg.sv
// Shared types for the CAN transmit buffer lock controller.
package cantxl_pkg;
    // Sequencer phases: waiting, preparing before start of frame, on the bus.
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_PREP = 2'd1,
        SQ_XMIT = 2'd2
    } sq_state_t;
endpackage

// File: rtl/txl_pick.sv
// Lowest-index picker.
// Returns the index of the lowest set bit of pend and whether any bit is set.
// Assumes NBUF >= 1; purely combinational.
module txl_pick #(
    parameter int NBUF  = 4,
    parameter int IDX_W = 2
) (
    input  logic [NBUF-1:0]  pend,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so that the lowest set bit is the last one written.
    always_comb begin
        any = |pend;
        idx = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/txl_regs.sv
// Per-buffer lock, ready and complete bits.
// Assumes that at most one host action arrives per cycle. xmit_mask marks
// the buffer on the bus, whose lock cannot be dropped. ok_set marks a
// successful attempt.
module txl_regs #(
    parameter int NBUF = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lock_wr,
    input  logic [NBUF-1:0] lock_wdata,
    input  logic [NBUF-1:0] trig_vec,
    input  logic            w1c_wr,
    input  logic [NBUF-1:0] w1c_data,
    input  logic [NBUF-1:0] xmit_mask,
    input  logic [NBUF-1:0] ok_set,
    output logic [NBUF-1:0] lock_q,
    output logic [NBUF-1:0] rdy_q,
    output logic [NBUF-1:0] done_q,
    output logic [NBUF-1:0] lock_clr
);
    logic [NBUF-1:0] lock_d, rdy_d, done_d;

    // Locks being dropped by this write, excluding the buffer on the bus.
    assign lock_clr = lock_wr ? (lock_q & ~lock_wdata & ~xmit_mask) : '0;

    // Next-state logic, one slice per buffer.
    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        assign lock_d[i] = lock_wr ? (lock_wdata[i] | xmit_mask[i]) : lock_q[i];
        assign rdy_d[i]  = lock_clr[i]               ? 1'b0 :
                           ok_set[i]                 ? 1'b0 :
                           (trig_vec[i] & lock_q[i]) ? 1'b1 : rdy_q[i];
        assign done_d[i] = ok_set[i] | (done_q[i] & ~(w1c_wr & w1c_data[i]));
    end

    // State update with synchronous reset to all-receive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
            rdy_q  <= '0;
            done_q <= '0;
        end else begin
            lock_q <= lock_d;
            rdy_q  <= rdy_d;
            done_q <= done_d;
        end
    end

    AST_RDY_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_q & ~lock_q) == '0); // R3
    AST_XMIT_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (xmit_mask != '0) |-> ((xmit_mask & lock_q) == xmit_mask)); // R8
    AST_DONE_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_set != '0) |=> ((done_q & $past(ok_set)) == $past(ok_set))); // R9
endmodule

// File: rtl/txl_seq.sv
// Transmission sequencer.
// It latches the picked buffer, counts PREP_BITS bit ticks, then issues
// start of frame and waits for the end of the attempt. Assumes pend is
// lock AND ready from the register slice. lock_clr is this cycle's lock drop.
module txl_seq
    import cantxl_pkg::*;
#(
    parameter int NBUF      = 4,
    parameter int IDX_W     = 2,
    parameter int PREP_BITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBUF-1:0]  pend,
    input  logic             pick_any,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic [NBUF-1:0]  lock_clr,
    input  logic             bit_tick,
    input  logic             eoa,
    input  logic             eoa_ok,
    output logic             prep,
    output logic             xmit,
    output logic             sof,
    output logic [IDX_W-1:0] sel,
    output logic [NBUF-1:0]  xmit_mask,
    output logic [NBUF-1:0]  ok_set
);
    localparam int CNT_W = $clog2(PREP_BITS + 1);

    sq_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic             cancel;
    logic             last_tick;
    logic [NBUF-1:0]  sel_hot;

    // Decode the selection and the preparation exit conditions.
    always_comb begin
        sel_hot   = NBUF'(1) << sel;
        cancel    = (state == SQ_PREP) && (lock_clr[sel] || !pend[sel]);
        last_tick = bit_tick && (cnt == CNT_W'(PREP_BITS - 1));
        prep      = (state == SQ_PREP);
        xmit      = (state == SQ_XMIT);
        xmit_mask = xmit ? sel_hot : '0;
        ok_set    = (xmit && eoa && eoa_ok) ? sel_hot : '0;
    end

    // Phase sequencing: pick, prepare, send, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            sel   <= '0;
            sof   <= 1'b0;
        end else begin
            sof <= 1'b0;
            case (state)
                SQ_IDLE: if (pick_any) begin
                    state <= SQ_PREP;
                    sel   <= pick_idx;
                    cnt   <= '0;
                end
                SQ_PREP: if (cancel) begin
                    state <= SQ_IDLE;
                end else if (last_tick) begin
                    state <= SQ_XMIT;
                    sof   <= 1'b1;
                end else if (bit_tick) begin
                    cnt <= cnt + 1'b1;
                end
                SQ_XMIT: if (eoa) state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE && $past(state) != SQ_IDLE) |-> $stable(sel)); // R5
    AST_SOF_AFTER_PREP: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> $past(state) == SQ_PREP); // R6
    AST_SOF_RIGHT_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> pend[sel]); // R7
endmodule

// File: rtl/can_txlock_ctrl.sv
// CAN transmit buffer lock controller (top).
// It decodes the host port and ties the register slice, the picker and the
// sequencer together. Address map: bit ADDR_W-1 clear selects a buffer byte
// {buffer, byte}. Set, it selects the control page: lock register at offset
// 0, complete-clear at offset 1.
module can_txlock_ctrl #(
    parameter int NBUF      = 4,
    parameter int PREP_BITS = 2,
    localparam int IDX_W    = (NBUF > 1) ? $clog2(NBUF) : 1,
    localparam int ADDR_W   = IDX_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [NBUF-1:0]   host_wdata,
    input  logic              bit_tick_i,
    input  logic              eoa_i,
    input  logic              eoa_ok_i,
    output logic [NBUF-1:0]   lock_o,
    output logic [NBUF-1:0]   rdy_o,
    output logic [NBUF-1:0]   done_o,
    output logic              prep_o,
    output logic              active_o,
    output logic              sof_o,
    output logic [IDX_W-1:0]  sel_o
);
    localparam logic [ADDR_W-1:0] CTL_LOCK = {1'b1, {(ADDR_W-1){1'b0}}};
    localparam logic [ADDR_W-1:0] CTL_DONE = CTL_LOCK + 1'b1;

    logic             lock_wr, w1c_wr;
    logic [NBUF-1:0]  trig_vec, lock_clr, xmit_mask, ok_set, pend;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;

    // Host decode: the control writes and the byte-7 request trigger.
    always_comb begin
        lock_wr  = host_we && (host_addr == CTL_LOCK);
        w1c_wr   = host_we && (host_addr == CTL_DONE);
        trig_vec = '0;
        if (host_we && !host_addr[ADDR_W-1] && host_addr[2:0] == 3'd7)
            trig_vec = NBUF'(1) << host_addr[IDX_W+2:3];
    end

    assign pend = lock_o & rdy_o;

    txl_regs #(.NBUF(NBUF)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_wr    (lock_wr),
        .lock_wdata (host_wdata),
        .trig_vec   (trig_vec),
        .w1c_wr     (w1c_wr),
        .w1c_data   (host_wdata),
        .xmit_mask  (xmit_mask),
        .ok_set     (ok_set),
        .lock_q     (lock_o),
        .rdy_q      (rdy_o),
        .done_q     (done_o),
        .lock_clr   (lock_clr)
    );

    txl_pick #(.NBUF(NBUF), .IDX_W(IDX_W)) u_pick (
        .pend (pend),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    txl_seq #(.NBUF(NBUF), .IDX_W(IDX_W), .PREP_BITS(PREP_BITS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .pick_any  (pick_any),
        .pick_idx  (pick_idx),
        .lock_clr  (lock_clr),
        .bit_tick  (bit_tick_i),
        .eoa       (eoa_i),
        .eoa_ok    (eoa_ok_i),
        .prep      (prep_o),
        .xmit      (active_o),
        .sof       (sof_o),
        .sel       (sel_o),
        .xmit_mask (xmit_mask),
        .ok_set    (ok_set)
    );

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(prep_o && active_o)); // R6
endmodule

// File: tb/can_txlock_ctrl_tb.sv
`timescale 1ns/1ps
module can_txlock_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [5:0] host_addr = '0;
    logic [3:0] host_wdata = '0;
    logic       bit_tick_i = 1'b0, eoa_i = 1'b0, eoa_ok_i = 1'b0;
    logic [3:0] lock_o, rdy_o, done_o;
    logic       prep_o, active_o, sof_o;
    logic [1:0] sel_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    can_txlock_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .bit_tick_i(bit_tick_i), .eoa_i(eoa_i),
        .eoa_ok_i(eoa_ok_i), .lock_o(lock_o), .rdy_o(rdy_o), .done_o(done_o),
        .prep_o(prep_o), .active_o(active_o), .sof_o(sof_o), .sel_o(sel_o)
    );

    // Stimulus and expected outputs after one clock edge.
    typedef struct packed {
        logic [3:0] req;
        logic       we;
        logic [5:0] addr;
        logic [3:0] wd;
        logic       tk, eo, ok;
        logic [3:0] lk, rd, dn;
        logic       pp, ac, sf;
        logic [1:0] sl;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{4'd2,  1'b1, 6'h20, 4'h6, 1'b0,1'b0,1'b0, 4'h6,4'h0,4'h0, 1'b0,1'b0,1'b0, 2'd0}, // R2 lock 1,2
        '{4'd3,  1'b1, 6'h17, 4'h0, 1'b0,1'b0,1'b0, 4'h6,4'h4,4'h0, 1'b0,1'b0,1'b0, 2'd0}, // R3 request buf2
        '{4'd5,  1'b1, 6'h0F, 4'h0, 1'b0,1'b0,1'b0, 4'h6,4'h6,4'h0, 1'b1,1'b0,1'b0, 2'd2}, // R5 pick 2, freeze
        '{4'd5,  1'b0, 6'h00, 4'h0, 1'b0,1'b0,1'b0, 4'h6,4'h6,4'h0, 1'b1,1'b0,1'b0, 2'd2}, // R5 still 2
        '{4'd6,  1'b0, 6'h00, 4'h0, 1'b1,1'b0,1'b0, 4'h6,4'h6,4'h0, 1'b1,1'b0,1'b0, 2'd2}, // R6 tick 1
        '{4'd6,  1'b0, 6'h00, 4'h0, 1'b1,1'b0,1'b0, 4'h6,4'h6,4'h0, 1'b0,1'b1,1'b1, 2'd2}, // R6 tick 2 sof
        '{4'd6,  1'b0, 6'h00, 4'h0, 1'b0,1'b0,1'b0, 4'h6,4'h6,4'h0, 1'b0,1'b1,1'b0, 2'd2}, // R6 sof one cycle
        '{4'd9,  1'b0, 6'h00, 4'h0, 1'b0,1'b1,1'b1, 4'h6,4'h2,4'h4, 1'b0,1'b0,1'b0, 2'd2}, // R9 success
        '{4'd5,  1'b0, 6'h00, 4'h0, 1'b0,1'b0,1'b0, 4'h6,4'h2,4'h4, 1'b1,1'b0,1'b0, 2'd1}, // R5 next pick 1
        '{4'd6,  1'b0, 6'h00, 4'h0, 1'b1,1'b0,1'b0, 4'h6,4'h2,4'h4, 1'b1,1'b0,1'b0, 2'd1}, // R6 tick 1
        '{4'd7,  1'b1, 6'h20, 4'h4, 1'b0,1'b0,1'b0, 4'h4,4'h0,4'h4, 1'b0,1'b0,1'b0, 2'd1}, // R7 cancel prep
        '{4'd10, 1'b1, 6'h21, 4'h4, 1'b0,1'b0,1'b0, 4'h4,4'h0,4'h0, 1'b0,1'b0,1'b0, 2'd1}, // R10 w1c
        '{4'd11, 1'b0, 6'h00, 4'h0, 1'b0,1'b1,1'b1, 4'h4,4'h0,4'h0, 1'b0,1'b0,1'b0, 2'd1}  // R11 stray eoa
    };

    // Apply inputs after a falling edge, return at the next falling edge.
    task automatic step(input logic we, input logic [5:0] a, input logic [3:0] d,
                        input logic tk, input logic eo, input logic ok);
        host_we = we; host_addr = a; host_wdata = d;
        bit_tick_i = tk; eoa_i = eo; eoa_ok_i = ok;
        @(negedge clk);
        host_we = 1'b0; bit_tick_i = 1'b0; eoa_i = 1'b0; eoa_ok_i = 1'b0;
    endtask

    // Compare all outputs against the expected value.
    task automatic chk(input string req, input logic [3:0] lk, input logic [3:0] rd,
                       input logic [3:0] dn, input logic pp, input logic ac,
                       input logic sf, input logic [1:0] sl);
        logic [16:0] got, exp;
        got = {lock_o, rdy_o, done_o, prep_o, active_o, sof_o, sel_o};
        exp = {lk, rd, dn, pp, ac, sf, sl};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got lock=%h rdy=%h done=%h prep=%b act=%b sof=%b sel=%0d exp %h",
                     req, lock_o, rdy_o, done_o, prep_o, active_o, sof_o, sel_o, exp);
        end
    endtask

    task automatic run(input string req, input logic we, input logic [5:0] a,
                       input logic [3:0] d, input logic tk, input logic eo, input logic ok,
                       input logic [3:0] lk, input logic [3:0] rd, input logic [3:0] dn,
                       input logic pp, input logic ac, input logic sf, input logic [1:0] sl);
        step(we, a, d, tk, eo, ok);
        chk(req, lk, rd, dn, pp, ac, sf, sl);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].we, TBL[i].addr, TBL[i].wd, TBL[i].tk, TBL[i].eo, TBL[i].ok);
            chk($sformatf("R%0d vec%0d", TBL[i].req, i), TBL[i].lk, TBL[i].rd, TBL[i].dn,
                TBL[i].pp, TBL[i].ac, TBL[i].sf, TBL[i].sl);
        end

        // R7: lock drop in the same cycle as the final preparation tick.
        run("R2",  1, 6'h20, 4'h1, 0,0,0, 4'h1,4'h0,4'h0, 0,0,0, 2'd1);
        run("R3",  1, 6'h07, 4'h0, 0,0,0, 4'h1,4'h1,4'h0, 0,0,0, 2'd1);
        run("R5",  0, 6'h00, 4'h0, 0,0,0, 4'h1,4'h1,4'h0, 1,0,0, 2'd0);
        run("R6",  0, 6'h00, 4'h0, 1,0,0, 4'h1,4'h1,4'h0, 1,0,0, 2'd0);
        run("R7 same-cycle", 1, 6'h20, 4'h0, 1,0,0, 4'h0,4'h0,4'h0, 0,0,0, 2'd0);
        run("R7 no late sof", 0, 6'h00, 4'h0, 0,0,0, 4'h0,4'h0,4'h0, 0,0,0, 2'd0);

        // R4, R8, R9: abort of a waiting buffer, lock held on bus, retry.
        run("R2",  1, 6'h20, 4'h3, 0,0,0, 4'h3,4'h0,4'h0, 0,0,0, 2'd0);
        run("R3",  1, 6'h07, 4'h0, 0,0,0, 4'h3,4'h1,4'h0, 0,0,0, 2'd0);
        run("R5",  1, 6'h0F, 4'h0, 0,0,0, 4'h3,4'h3,4'h0, 1,0,0, 2'd0);
        run("R4",  1, 6'h20, 4'h1, 0,0,0, 4'h1,4'h1,4'h0, 1,0,0, 2'd0);
        run("R6",  0, 6'h00, 4'h0, 1,0,0, 4'h1,4'h1,4'h0, 1,0,0, 2'd0);
        run("R6",  0, 6'h00, 4'h0, 1,0,0, 4'h1,4'h1,4'h0, 0,1,1, 2'd0);
        run("R8 hold", 1, 6'h20, 4'h0, 0,0,0, 4'h1,4'h1,4'h0, 0,1,0, 2'd0);
        run("R9 fail", 0, 6'h00, 4'h0, 0,1,0, 4'h1,4'h1,4'h0, 0,0,0, 2'd0);
        run("R9 retry", 0, 6'h00, 4'h0, 0,0,0, 4'h1,4'h1,4'h0, 1,0,0, 2'd0);
        run("R8 reclear", 1, 6'h20, 4'h0, 0,0,0, 4'h0,4'h0,4'h0, 0,0,0, 2'd0);

        // R3 ignored writes, R10 set-versus-clear collision, R5 lowest pick.
        run("R3 unlocked", 1, 6'h1F, 4'h0, 0,0,0, 4'h0,4'h0,4'h0, 0,0,0, 2'd0);
        run("R2",  1, 6'h20, 4'hD, 0,0,0, 4'hD,4'h0,4'h0, 0,0,0, 2'd0);
        run("R3 byte3", 1, 6'h03, 4'h0, 0,0,0, 4'hD,4'h0,4'h0, 0,0,0, 2'd0);
        run("R3",  1, 6'h07, 4'h0, 0,0,0, 4'hD,4'h1,4'h0, 0,0,0, 2'd0);
        run("R5",  1, 6'h1F, 4'h0, 0,0,0, 4'hD,4'h9,4'h0, 1,0,0, 2'd0);
        run("R5",  1, 6'h17, 4'h0, 0,0,0, 4'hD,4'hD,4'h0, 1,0,0, 2'd0);
        run("R6",  0, 6'h00, 4'h0, 1,0,0, 4'hD,4'hD,4'h0, 1,0,0, 2'd0);
        run("R6",  0, 6'h00, 4'h0, 1,0,0, 4'hD,4'hD,4'h0, 0,1,1, 2'd0);
        run("R10 set wins", 1, 6'h21, 4'h1, 0,1,1, 4'hD,4'hC,4'h1, 0,0,0, 2'd0);
        run("R5 lowest", 0, 6'h00, 4'h0, 0,0,0, 4'hD,4'hC,4'h1, 1,0,0, 2'd2);
        run("R4 other", 1, 6'h20, 4'h5, 0,0,0, 4'h5,4'h4,4'h1, 1,0,0, 2'd2);

        // R1: reset in the middle of preparation.
        rst_n = 1'b0;
        step(0, 6'h00, 4'h0, 0, 0, 0);
        chk("R1 mid-run reset", 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 2'd0);
        rst_n = 1'b1;
        run("R1 stays idle", 0, 6'h00, 4'h0, 1,1,1, 4'h0,4'h0,4'h0, 0,0,0, 2'd0);

        summary();
    end
endmodule